// File: doc/BRIEF.md
# Per-Process Page Translation Unit

This block turns a linear address into a physical address by looking it up in a private translation memory. That memory sits apart from main RAM. It holds one flat table per process. A process register, loaded by the supervisor, selects the table, and the page field of the linear address selects the entry inside it. Each entry holds a physical page base, a supervisor-only flag, a write-permit flag, a modified flag and the number of the process that owns the page.

A lookup takes two cycles. In the first cycle the entry is read from the synchronous memory. In the second cycle the entry is checked, and the block then returns either a physical address or a fault code. The check rejects three cases, and gives each one a priority: the owner stamp does not match the current process, a user access hits a supervisor-only page, or a write hits a page that does not permit writes. An ownership check of this kind stops a linear address that wraps or runs past its range from landing in the pages of another process. When a write is accepted, the block sets the modified flag in the entry through a read-modify-write one cycle later. A supervisor write port can rewrite any entry at any time.

Top module: `ptu_xlate`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid` is 0 and `rsp_fault`, `rsp_phys_addr` and `rsp_dirty` are all zero until a request has been accepted.
- R2: Every cycle with `req_valid` high gives exactly one response, two clock edges later. Requests may be issued back to back, and a cycle without a request gives no response.
- R3: The entry index is {current process, linear bits [21:12]}. Linear bits above 21 are ignored. On success, `rsp_phys_addr` = {entry bits [31:22], linear bits [11:0]} and `rsp_fault` = 0.
- R4: If entry bits [PROC_W-1:0] differ from the current process, `rsp_fault` = 1 (owner mismatch), `rsp_phys_addr` = 0 and `rsp_dirty` = 0.
- R5: A user access (`req_user`=1) to an entry with bit 21 (supervisor-only) set gives `rsp_fault` = 2.
- R6: A write (`req_write`=1) to an entry with bit 20 (write permit) clear gives `rsp_fault` = 3, in user and supervisor mode alike.
- R7: When several faults apply, owner mismatch (1) wins over supervisor-only (2), and supervisor-only wins over write permit (3).
- R8: `rsp_dirty` reports entry bit 19 (modified) as stored when the entry was read. A successful write sets bit 19 in that entry, so a later lookup of the same page reports `rsp_dirty` = 1.
- R9: Reads and faulting accesses leave bit 19 unchanged.
- R10: When `proc_load` is high, `proc_id_in` becomes the current process for requests in later cycles. A request in the same cycle still uses the old value.
- R11: A supervisor table write is accepted in any cycle. When it arrives in the same cycle as a lookup of the same index, the write takes priority and the lookup sees the new entry.
- R12: A supervisor-mode access (`req_user`=0) to a supervisor-only page succeeds as long as the owner and write checks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_load | input | 1 | Load the current process register |
| proc_id_in | input | PROC_W | New current process number |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request is made in user mode |
| req_lin_addr | input | LIN_W | Linear address |
| tbl_wr_en | input | 1 | Supervisor table write strobe |
| tbl_wr_idx | input | PROC_W+PAGE_W | Entry index to write |
| tbl_wr_data | input | 32 | Entry value to write |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 2 | 0 ok, 1 owner mismatch, 2 supervisor-only, 3 write denied |
| rsp_phys_addr | output | 22 | Physical address, zero on fault |
| rsp_dirty | output | 1 | Stored modified flag of the entry |

## Verification
The hardest case to reach is a supervisor write that lands in the same cycle as a lookup of that same index, because the outcome depends on the memory's write-first forwarding. The stimulus drives both strobes in one cycle, first on the looked-up page and then on a different page. A later lookup then shows that the second entry was stored. The modified-flag update is checked in a similar way: a successful write is followed by a lookup of the same page a few cycles later, and a write that faulted is followed by a read of its page to show the flag is still clear.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
   localparam int ENTRY_W  = 32;
   localparam int BASE_LSB = 22;
   localparam int S_BIT    = 21;
   localparam int W_BIT    = 20;
   localparam int D_BIT    = 19;
   localparam int BASE_W   = ENTRY_W - BASE_LSB;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_OWNER = 2'd1,
      FLT_PRIV  = 2'd2,
      FLT_WRITE = 2'd3
   } ptu_fault_e;
endpackage

// File: rtl/ptu_table_ram.sv
module ptu_table_ram #(
   parameter int IDX_W       = 12,
   parameter int DATA_W      = 32,
   parameter int WRITE_FIRST = 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (WRITE_FIRST != 0) begin : g_wr_first
         always_ff @(posedge clk) begin
            if (we && (waddr == raddr)) rdata <= wdata;
            else                        rdata <= mem[raddr];
         end
      end else begin : g_rd_first
         always_ff @(posedge clk) begin
            rdata <= mem[raddr];
         end
      end
   endgenerate
endmodule

// File: rtl/ptu_entry_check.sv
module ptu_entry_check
   import ptu_pkg::*;
#(
   parameter int PROC_W = 2
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [PROC_W-1:0]  cur_proc,
   input  logic               is_user,
   input  logic               is_write,
   output ptu_fault_e         fault,
   output logic               stored_dirty,
   output logic [ENTRY_W-1:0] entry_marked
);
   logic owner_ok;
   logic priv_bad;
   logic write_bad;

   assign owner_ok  = (entry[PROC_W-1:0] == cur_proc);
   assign priv_bad  = is_user && entry[S_BIT];
   assign write_bad = is_write && !entry[W_BIT];

   always_comb begin
      if (!owner_ok)      fault = FLT_OWNER;
      else if (priv_bad)  fault = FLT_PRIV;
      else if (write_bad) fault = FLT_WRITE;
      else                fault = FLT_NONE;
   end

   assign stored_dirty = entry[D_BIT];

   always_comb begin
      entry_marked        = entry;
      entry_marked[D_BIT] = 1'b1;
   end
endmodule

// File: rtl/ptu_xlate.sv
module ptu_xlate
   import ptu_pkg::*;
#(
   parameter  int LIN_W       = 32,
   parameter  int PROC_W      = 2,
   parameter  int PAGE_W      = 10,
   parameter  int OFF_W       = 12,
   parameter  int WRITE_FIRST = 1,
   localparam int IDX_W       = PROC_W + PAGE_W,
   localparam int PA_W        = BASE_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               proc_load,
   input  logic [PROC_W-1:0]  proc_id_in,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [LIN_W-1:0]   req_lin_addr,
   input  logic               tbl_wr_en,
   input  logic [IDX_W-1:0]   tbl_wr_idx,
   input  logic [ENTRY_W-1:0] tbl_wr_data,
   output logic               rsp_valid,
   output logic [1:0]         rsp_fault,
   output logic [PA_W-1:0]    rsp_phys_addr,
   output logic               rsp_dirty
);
   // elaboration-time parameter checks
   generate
      if (PROC_W < 1 || PROC_W > D_BIT) begin : g_bad_proc
         $error("ptu_xlate: PROC_W must fit below the modified flag");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("ptu_xlate: PAGE_W must be at least 1");
      end
      if (OFF_W + PAGE_W >= LIN_W) begin : g_bad_lin
         $error("ptu_xlate: LIN_W must exceed OFF_W + PAGE_W");
      end
      if (IDX_W > 20) begin : g_bad_idx
         $error("ptu_xlate: translation memory index too wide");
      end
   endgenerate

   // current process register
   logic [PROC_W-1:0] cur_proc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         cur_proc_q <= '0;
      else if (proc_load) cur_proc_q <= proc_id_in;
   end

   // lookup index
   logic [IDX_W-1:0] lk_idx;
   logic             unused_hi;

   assign lk_idx    = {cur_proc_q, req_lin_addr[OFF_W+PAGE_W-1:OFF_W]};
   assign unused_hi = ^req_lin_addr[LIN_W-1:OFF_W+PAGE_W];

   // stage 1: request held while the entry is read
   logic              s1_valid;
   logic              s1_write;
   logic              s1_user;
   logic [OFF_W-1:0]  s1_off;
   logic [IDX_W-1:0]  s1_idx;
   logic [PROC_W-1:0] s1_proc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_write <= 1'b0;
         s1_user  <= 1'b0;
         s1_off   <= '0;
         s1_idx   <= '0;
         s1_proc  <= '0;
      end else begin
         s1_valid <= req_valid;
         s1_write <= req_write;
         s1_user  <= req_user;
         s1_off   <= req_lin_addr[OFF_W-1:0];
         s1_idx   <= lk_idx;
         s1_proc  <= cur_proc_q;
      end
   end

   // translation memory, single write port shared by supervisor and writeback
   logic               wb_valid;
   logic [IDX_W-1:0]   wb_idx;
   logic [ENTRY_W-1:0] wb_data;
   logic               ram_we;
   logic [IDX_W-1:0]   ram_waddr;
   logic [ENTRY_W-1:0] ram_wdata;
   logic [ENTRY_W-1:0] ram_rdata;

   always_comb begin
      ram_we = tbl_wr_en || wb_valid;
      if (tbl_wr_en) begin
         ram_waddr = tbl_wr_idx;
         ram_wdata = tbl_wr_data;
      end else begin
         ram_waddr = wb_idx;
         ram_wdata = wb_data;
      end
   end

   ptu_table_ram #(
      .IDX_W       (IDX_W),
      .DATA_W      (ENTRY_W),
      .WRITE_FIRST (WRITE_FIRST)
   ) tbl_ram_i (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (lk_idx),
      .rdata (ram_rdata)
   );

   // stage 2: check
   ptu_fault_e         ck_fault;
   logic               ck_dirty;
   logic [ENTRY_W-1:0] ck_marked;
   logic               ck_ok;

   ptu_entry_check #(
      .PROC_W (PROC_W)
   ) check_i (
      .entry        (ram_rdata),
      .cur_proc     (s1_proc),
      .is_user      (s1_user),
      .is_write     (s1_write),
      .fault        (ck_fault),
      .stored_dirty (ck_dirty),
      .entry_marked (ck_marked)
   );

   assign ck_ok = (ck_fault == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_fault     <= 2'd0;
         rsp_phys_addr <= '0;
         rsp_dirty     <= 1'b0;
      end else begin
         rsp_valid     <= s1_valid;
         rsp_fault     <= s1_valid ? 2'(ck_fault) : 2'd0;
         rsp_phys_addr <= (s1_valid && ck_ok) ?
                          {ram_rdata[ENTRY_W-1:BASE_LSB], s1_off} : '0;
         rsp_dirty     <= s1_valid && ck_ok && ck_dirty;
      end
   end

   // modified-flag writeback, one cycle after the check
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= s1_valid && s1_write && ck_ok && !ck_dirty &&
                     !(tbl_wr_en && (tbl_wr_idx == s1_idx));
         wb_idx   <= s1_idx;
         wb_data  <= ck_marked;
      end
   end
endmodule

// File: rtl/ptu_xlate_chk.sv
module ptu_xlate_chk #(
   parameter int LIN_W  = 32,
   parameter int PROC_W = 2,
   parameter int OFF_W  = 12,
   parameter int PA_W   = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              proc_load,
   input logic [PROC_W-1:0] proc_id_in,
   input logic              req_valid,
   input logic [LIN_W-1:0]  req_lin_addr,
   input logic [PROC_W-1:0] cur_proc_q,
   input logic              wb_valid,
   input logic              rsp_valid,
   input logic [1:0]        rsp_fault,
   input logic [PA_W-1:0]   rsp_phys_addr,
   input logic              rsp_dirty
);
   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_fault == 2'd0 && rsp_phys_addr == '0 && !rsp_dirty));

   a_r2_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ##2 rsp_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> ##2 !rsp_valid);

   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd0) |->
         rsp_phys_addr[OFF_W-1:0] == $past(req_lin_addr[OFF_W-1:0], 2));

   a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_phys_addr == '0 && !rsp_dirty));

   a_r8_mark_on_success: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (rsp_valid && rsp_fault == 2'd0 && !rsp_dirty));

   a_r10_proc_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      proc_load |=> cur_proc_q == $past(proc_id_in));
endmodule

bind ptu_xlate ptu_xlate_chk #(
   .LIN_W  (LIN_W),
   .PROC_W (PROC_W),
   .OFF_W  (OFF_W),
   .PA_W   (PA_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .proc_load     (proc_load),
   .proc_id_in    (proc_id_in),
   .req_valid     (req_valid),
   .req_lin_addr  (req_lin_addr),
   .cur_proc_q    (cur_proc_q),
   .wb_valid      (wb_valid),
   .rsp_valid     (rsp_valid),
   .rsp_fault     (rsp_fault),
   .rsp_phys_addr (rsp_phys_addr),
   .rsp_dirty     (rsp_dirty)
);

// File: tb/ptu_xlate_tb_top.sv
module ptu_xlate_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LIN_W  = 32;
   localparam int PROC_W = 2;
   localparam int PAGE_W = 10;
   localparam int IDX_W  = PROC_W + PAGE_W;
   localparam int PA_W   = 22;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              proc_load = 1'b0;
   logic [PROC_W-1:0] proc_id_in = '0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic              req_user = 1'b0;
   logic [LIN_W-1:0]  req_lin_addr = '0;
   logic              tbl_wr_en = 1'b0;
   logic [IDX_W-1:0]  tbl_wr_idx = '0;
   logic [31:0]       tbl_wr_data = '0;
   logic              rsp_valid;
   logic [1:0]        rsp_fault;
   logic [PA_W-1:0]   rsp_phys_addr;
   logic              rsp_dirty;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptu_xlate dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .proc_load     (proc_load),
      .proc_id_in    (proc_id_in),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_user      (req_user),
      .req_lin_addr  (req_lin_addr),
      .tbl_wr_en     (tbl_wr_en),
      .tbl_wr_idx    (tbl_wr_idx),
      .tbl_wr_data   (tbl_wr_data),
      .rsp_valid     (rsp_valid),
      .rsp_fault     (rsp_fault),
      .rsp_phys_addr (rsp_phys_addr),
      .rsp_dirty     (rsp_dirty)
   );

   typedef struct {
      logic [PA_W-1:0] phys;
      logic [1:0]      fault;
      logic            dirty;
      string           tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] model [int];
   logic [1:0]  cur_proc_m = '0;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   function automatic logic [31:0] mk(input logic [9:0] base, input logic s,
                                      input logic w, input logic d,
                                      input logic [1:0] owner);
      return {base, s, w, d, 12'd0, 5'd0, owner};
   endfunction

   function automatic int ix(input int p, input int pg);
      return p * 1024 + pg;
   endfunction

   task automatic step(input logic rv, input logic rw, input logic ru,
                       input logic [31:0] la, input logic tw, input int tidx,
                       input logic [31:0] tdat, input logic pl,
                       input logic [1:0] pid, input string tag);
      exp_t        e;
      logic [31:0] ent;
      int          idx;
      req_valid    = rv;
      req_write    = rw;
      req_user     = ru;
      req_lin_addr = la;
      tbl_wr_en    = tw;
      tbl_wr_idx   = IDX_W'(tidx);
      tbl_wr_data  = tdat;
      proc_load    = pl;
      proc_id_in   = pid;
      if (tw) model[tidx] = tdat;
      if (rv) begin
         idx = int'({cur_proc_m, la[21:12]});
         ent = model.exists(idx) ? model[idx] : 32'd0;
         e.tag = tag;
         if (ent[1:0] != cur_proc_m)   e.fault = 2'd1;
         else if (ru && ent[21])       e.fault = 2'd2;
         else if (rw && !ent[20])      e.fault = 2'd3;
         else                          e.fault = 2'd0;
         e.phys  = (e.fault == 2'd0) ? {ent[31:22], la[11:0]} : '0;
         e.dirty = (e.fault == 2'd0) && ent[19];
         if (e.fault == 2'd0 && rw) begin
            ent[19] = 1'b1;
            model[idx] = ent;
         end
         sb_q.push_back(e);
      end
      if (pl) cur_proc_m = pid;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic rd(input logic user, input logic [31:0] la, input string tag);
      step(1, 0, user, la, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic user, input logic [31:0] la, input string tag);
      step(1, 1, user, la, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic tload(input int idx, input logic [31:0] v);
      step(0, 0, 0, 0, 1, idx, v, 0, 0, "");
   endtask

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && rsp_valid) begin
            n_vec++;
            if (sb_q.size() == 0) begin
               n_bad++;
               $display("FAIL R2: got unexpected response fault=%0d, expected none",
                        rsp_fault);
            end else begin
               e = sb_q.pop_front();
               if (rsp_phys_addr !== e.phys || rsp_fault !== e.fault ||
                   rsp_dirty !== e.dirty) begin
                  n_bad++;
                  $display("FAIL %s: got phys=%h fault=%0d dirty=%b, expected phys=%h fault=%0d dirty=%b",
                           e.tag, rsp_phys_addr, rsp_fault, rsp_dirty,
                           e.phys, e.fault, e.dirty);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no finish, expected end of stimulus");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      n_vec++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 2'd0 || rsp_phys_addr !== '0 ||
          rsp_dirty !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: got valid=%b fault=%0d phys=%h, expected 0 0 0",
                  rsp_valid, rsp_fault, rsp_phys_addr);
      end
      rst_n = 1'b1;
      @(negedge clk);
      idle(2);
      n_vec++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: got valid=%b after reset, expected 0", rsp_valid);
      end

      step(0, 0, 0, 0, 0, 0, 0, 1, 2'd1, "");
      tload(ix(1, 5),    mk(10'h2A5, 0, 1, 0, 2'd1));
      tload(ix(1, 6),    mk(10'h111, 1, 1, 0, 2'd1));
      tload(ix(1, 7),    mk(10'h0F0, 0, 0, 0, 2'd1));
      tload(ix(1, 1023), mk(10'h3FF, 0, 1, 0, 2'd1));
      tload(ix(1, 9),    mk(10'h055, 0, 1, 0, 2'd2));
      tload(ix(1, 10),   mk(10'h066, 1, 0, 0, 2'd3));
      tload(ix(1, 11),   mk(10'h077, 1, 0, 0, 2'd1));
      tload(ix(2, 5),    mk(10'h1C3, 0, 1, 0, 2'd2));

      // R3: translation, high bits ignored
      rd(1, 32'h0000_5ABC, "R3 basic");
      idle(1);
      rd(1, 32'hFFC0_5123, "R3 high bits ignored");
      idle(1);
      rd(1, 32'h003F_F000, "R3 last page");
      idle(2);
      // R5, R12
      rd(1, 32'h0000_6010, "R5 user on supervisor page");
      rd(0, 32'h0000_6010, "R12 supervisor on supervisor page");
      // R6
      wr(1, 32'h0000_7000, "R6 user write denied");
      wr(0, 32'h0000_7004, "R6 supervisor write denied");
      // R4
      rd(1, 32'h0000_9000, "R4 owner mismatch");
      // R7 priority
      wr(1, 32'h0000_A000, "R7 owner beats others");
      wr(1, 32'h0000_B000, "R7 supervisor beats write");
      idle(2);
      // R8: successful write marks the page
      wr(1, 32'h0000_5FF0, "R8 first write clean");
      idle(2);
      rd(1, 32'h0000_5000, "R8 page now modified");
      idle(1);
      // R9: faulting write left the flag clear
      rd(0, 32'h0000_7008, "R9 fault left page clean");
      rd(0, 32'h0000_6000, "R9 read left page clean");
      // R2 back to back
      rd(1, 32'h0000_5001, "R2 back to back a");
      rd(1, 32'h003F_F002, "R2 back to back b");
      rd(1, 32'h0000_9003, "R2 back to back c");
      idle(2);
      // R11: supervisor write in the same cycle as a lookup
      step(1, 0, 1, 32'h0000_C0AA, 1, ix(1, 12), mk(10'h1AB, 0, 1, 0, 2'd1),
           0, 0, "R11 same index sees new entry");
      step(1, 0, 1, 32'h0000_5004, 1, ix(1, 12), mk(10'h2CD, 0, 1, 0, 2'd1),
           0, 0, "R11 other index lookup");
      idle(1);
      rd(1, 32'h0000_C0BB, "R11 entry stored");
      idle(2);
      // R10: process switch
      step(1, 0, 1, 32'h0000_5077, 0, 0, 0, 1, 2'd2, "R10 old process in load cycle");
      rd(1, 32'h0000_5077, "R10 new process table");
      rd(1, 32'h0000_9000, "R10 unwritten entry faults");
      idle(4);

      n_vec++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2: got %0d missing responses, expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule